// File: doc/BRIEF.md
# Quad-Channel Serial Code Register Front-End

This block is the digital control logic of a four-channel, 12-bit serial-input converter. A host shifts 16-bit frames in over three pins: an active-low select, a serial clock and a data line. A register-load strobe copies the code field of the frame into one of four input registers, picked by the address field. A load-all strobe then copies all four input registers into the output registers at once. The output registers drive the four 12-bit code buses. Together, the two strobes let the host set up new codes on each channel and then switch every output at the same moment.

Every pin is oversampled in a fast system clock domain. The shift clock is the logical OR of select and serial clock, and both register stages are level-transparent. As a result the block also reproduces the real misuse effects of the serial interface: an extra shift when select rises while the clock is low, and corrupted channels when shifting happens with the register-load strobe held low. A clear pin with a selectable code forces every input and output register to zero-scale or mid-scale.

Top module: `quad_dac_frontend`

## Requirements
- R1: A frame is 16 bits, sent most significant bit first. Bits 15:14 hold the channel address, bits 13:12 are ignored, and bits 11:0 hold the code.
- R2: Address 00 selects channel A on `dac_codes[11:0]`, 01 selects B on `[23:12]`, 10 selects C on `[35:24]` and 11 selects D on `[47:36]`.
- R3: The shift register moves one bit on every rising edge of (`cs_n` OR `sclk`). Toggling `cs_n` with `sclk` held low therefore shifts data just as `sclk` does.
- R4: When `cs_n` rises while `sclk` is low, the shift register takes one extra bit, which is the current `sdin` value.
- R5: While `ld_reg_n` is low, the input register addressed by the shift register follows the code field. It holds once `ld_reg_n` is high. Loading an input register while `ld_all_n` is high leaves every output code unchanged.
- R6: While `ld_all_n` is low, all four output codes follow their input registers. They hold while `ld_all_n` is high.
- R7: If shifting occurs while `ld_reg_n` is low, every channel addressed by any intermediate shift-register state takes that state's code field.
- R8: While `clr_n` is low, every input and output register is forced to 000h if `clr_mid` is 0 and to 800h if it is 1. This has priority over both load strobes.
- R9: A clear leaves the shift register unchanged, so a register load after the clear uses the frame shifted in before it.
- R10: After `clr_n` returns high, registers whose strobe is inactive keep the clear code.
- R11: `dac_upd` pulses for exactly one cycle for each cycle in which any output code changes. It stays low when a load-all copies identical values.
- R12: The synchronous `rst` sets all output codes to 000h and `dac_upd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial pins |
| rst | input | 1 | Synchronous active-high system reset |
| cs_n | input | 1 | Active-low select; OR-ed with `sclk` to form the shift clock |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data, most significant bit first |
| ld_reg_n | input | 1 | Active-low level strobe for the addressed input register |
| ld_all_n | input | 1 | Active-low level strobe for all output registers |
| clr_n | input | 1 | Active-low clear of input and output registers |
| clr_mid | input | 1 | Clear code select: 0 gives 000h, 1 gives 800h |
| dac_codes | output | 48 | Four 12-bit output codes, channel A in the low bits |
| dac_upd | output | 1 | One-cycle pulse when any output code changed |

## Verification
The assertions assume that every pin holds still for several system clock cycles between changes. A new level must reach the synchronized side before the next change, so that each shift-register state exists for at least one cycle in which a transparent register can copy it. The assertions also assume that `sdin` settles no later than the shift-clock edge that samples it. The stimulus changes pins only on falling system clock edges and waits five cycles after each change. It sets data during the low phase of the shift clock, so every edge and every intermediate state is seen exactly once.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Serial and control pins as seen by the synchronizer.
  typedef struct packed {
    logic clr_mid;
    logic clr_n;
    logic ld_all_n;
    logic ld_reg_n;
    logic sdin;
    logic sclk;
    logic cs_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{clr_mid: 1'b0, clr_n: 1'b1, ld_all_n: 1'b1,
                                  ld_reg_n: 1'b1, sdin: 1'b0, sclk: 1'b0,
                                  cs_n: 1'b1};

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdin,
  output logic [FRAME_W-1:0] frame_o
);
  logic or_now, or_prev, rise;

  assign or_now = cs_n | sclk;
  assign rise   = or_now & ~or_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      or_prev <= 1'b1;
      frame_o <= '0;
    end else begin
      or_prev <= or_now;
      if (rise) frame_o <= {frame_o[FRAME_W-2:0], sdin};
    end
  end

  // R3: no movement without an edge of the combined clock
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(frame_o));
  // R3: an edge advances the register by exactly one position
  p_shift_step_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> (frame_o[FRAME_W-1:1] == $past(frame_o[FRAME_W-2:0])));
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CODE_W-1:0]           code,
  input  logic                        ld_reg,
  input  logic                        ld_all,
  input  logic                        clr,
  input  logic                        clr_mid,
  output logic [NCH-1:0][CODE_W-1:0]  dac_q,
  output logic                        upd_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [NCH-1:0][CODE_W-1:0] in_q, in_d, dac_d;
  logic [CODE_W-1:0]          rcode;

  assign rcode = clr_mid ? MID_CODE : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel      = ld_reg && (addr == ADDR_W'(c));
    assign in_d[c]  = clr ? rcode : (sel ? code : in_q[c]);
    assign dac_d[c] = clr ? rcode : (ld_all ? in_q[c] : dac_q[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
      upd_o <= 1'b0;
    end else begin
      in_q  <= in_d;
      dac_q <= dac_d;
      upd_o <= (dac_d != dac_q);
    end
  end

  // R8: clear forces every output register to the selected code
  p_clr_force_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dac_q == {NCH{$past(rcode)}}));
  // R5: input registers hold while neither strobe nor clear is active
  p_in_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld_reg) |=> $stable(in_q));
  // R6: output registers hold without load-all or clear
  p_dac_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld_all) |=> $stable(dac_q));
  // R6: load-all copies the input registers
  p_dac_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && ld_all) |=> (dac_q == $past(in_q)));
  // R11: pulse only with a change, and every change pulses
  p_upd_change_r11: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (dac_q != $past(dac_q)));
  p_upd_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_o |-> $stable(dac_q));
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend #(
  parameter int CODE_W = 12,
  parameter int NCH    = 4,
  parameter int PAD_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    sdin,
  input  logic                    ld_reg_n,
  input  logic                    ld_all_n,
  input  logic                    clr_n,
  input  logic                    clr_mid,
  output logic [NCH*CODE_W-1:0]   dac_codes,
  output logic                    dac_upd
);
  import qdac_pkg::*;

  localparam int ADDR_W  = $clog2(NCH);
  localparam int FRAME_W = ADDR_W + PAD_W + CODE_W;

  pins_t                      raw_pins, s_pins;
  logic [FRAME_W-1:0]         frame;
  logic [NCH-1:0][CODE_W-1:0] dac_q;

  assign raw_pins = '{clr_mid: clr_mid, clr_n: clr_n, ld_all_n: ld_all_n,
                      ld_reg_n: ld_reg_n, sdin: sdin, sclk: sclk, cs_n: cs_n};

  qdac_sync #(.W($bits(pins_t)), .RST_VAL(PINS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_pins),
    .q   (s_pins)
  );

  qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (s_pins.cs_n),
    .sclk    (s_pins.sclk),
    .sdin    (s_pins.sdin),
    .frame_o (frame)
  );

  qdac_bank #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .addr    (frame[FRAME_W-1 -: ADDR_W]),
    .code    (frame[CODE_W-1:0]),
    .ld_reg  (~s_pins.ld_reg_n),
    .ld_all  (~s_pins.ld_all_n),
    .clr     (~s_pins.clr_n),
    .clr_mid (s_pins.clr_mid),
    .dac_q   (dac_q),
    .upd_o   (dac_upd)
  );

  assign dac_codes = dac_q;

  // R12: output codes are zero in the cycle after a system reset
  p_rst_zero_r12: assert property (@(posedge clk)
    rst |=> (dac_codes == '0 && !dac_upd));
endmodule

// File: tb/quad_dac_frontend_tb.sv
module quad_dac_frontend_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic ld_reg_n = 1'b1, ld_all_n = 1'b1, clr_n = 1'b1, clr_mid = 1'b0;
  logic [47:0] dac_codes;
  logic        dac_upd;

  int n_chk = 0, n_fail = 0, upd_cnt = 0;
  bit done = 0;
  logic [15:0] sh = '0;
  logic [11:0] m_in [4];
  logic [11:0] m_dac [4];

  always #2 clk = ~clk;  // 250 MHz

  quad_dac_frontend u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .ld_reg_n(ld_reg_n), .ld_all_n(ld_all_n), .clr_n(clr_n),
    .clr_mid(clr_mid), .dac_codes(dac_codes), .dac_upd(dac_upd)
  );

  always @(negedge clk) if (dac_upd) upd_cnt++;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_dacs(input string tag);
    for (int c = 0; c < 4; c++)
      check(tag, int'(dac_codes[c*12 +: 12]), int'(m_dac[c]));
  endtask

  task automatic mwrite();
    m_in[sh[15:14]] = sh[11:0];
  endtask

  // Frame shifted with sclk; optional ld_reg_n held low throughout (R7)
  task automatic send_frame(input logic [15:0] f, input bit hold_ld);
    cs_n = 1'b0; idle(5);
    if (hold_ld) begin ld_reg_n = 1'b0; idle(6); mwrite(); end
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0; sdin = f[i]; idle(5);
      sclk = 1'b1; idle(5);
      sh = {sh[14:0], f[i]};
      if (hold_ld) mwrite();
    end
    if (hold_ld) begin ld_reg_n = 1'b1; idle(5); end
    cs_n = 1'b1; idle(5);
  endtask

  task automatic pulse_reg();
    ld_reg_n = 1'b0; idle(6); ld_reg_n = 1'b1; idle(5);
    mwrite();
  endtask

  task automatic pulse_all();
    ld_all_n = 1'b0; idle(6); ld_all_n = 1'b1; idle(5);
    for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(4);
    check("R12 codes in reset", int'(dac_codes), 0);
    check("R12 upd in reset", int'(dac_upd), 0);
    rst = 1'b0; idle(4);
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    check_dacs("R12 after reset");
  endtask

  task automatic t_frames();
    send_frame(16'h3ABC, 0); pulse_reg();  // A, pad bits set (R1)
    send_frame(16'h4123, 0); pulse_reg();  // B
    send_frame(16'hB456, 0); pulse_reg();  // C
    send_frame(16'hC789, 0); pulse_reg();  // D
    check_dacs("R5 outputs held before load-all");
    upd_cnt = 0;
    pulse_all();
    check_dacs("R1 R2 four channels");
    check("R2 channel C code", int'(dac_codes[35:24]), 'h456);
    check("R11 one pulse on load-all", upd_cnt, 1);
    upd_cnt = 0;
    pulse_all();
    check("R11 no pulse on identical copy", upd_cnt, 0);
    check_dacs("R6 held after repeat copy");
  endtask

  task automatic t_cs_clock();
    sclk = 1'b0; idle(5);
    for (int i = 15; i >= 0; i--) begin
      cs_n = 1'b0; sdin = 16'hE9A5 >> i; idle(5);
      cs_n = 1'b1; idle(5);
      sh = {sh[14:0], 1'(16'hE9A5 >> i)};
    end
    sclk = 1'b1; idle(5);
    pulse_reg(); pulse_all();
    check("R3 select used as clock", int'(dac_codes[47:36]), 'h9A5);
    check_dacs("R3 all channels");
  endtask

  task automatic t_extra_edge();
    send_frame(16'h2AB3, 0);
    cs_n = 1'b0; idle(5);
    sclk = 1'b0; sdin = 1'b1; idle(5);
    cs_n = 1'b1; idle(5);
    sh = {sh[14:0], 1'b1};
    sclk = 1'b1; idle(5);
    pulse_reg(); pulse_all();
    check("R4 extra shift lands on B", int'(dac_codes[23:12]), 'h567);
    check_dacs("R4 all channels");
  endtask

  task automatic t_corrupt();
    send_frame(16'h8F0F, 1);
    upd_cnt = 0;
    idle(5);
    check("R5 no output change from register load", upd_cnt, 0);
    pulse_all();
    check_dacs("R7 corrupted channels");
  endtask

  task automatic t_clear();
    clr_mid = 1'b1; clr_n = 1'b0; ld_reg_n = 1'b0; ld_all_n = 1'b0; idle(8);
    for (int c = 0; c < 4; c++) begin m_in[c] = 12'h800; m_dac[c] = 12'h800; end
    check_dacs("R8 mid-scale over strobes");
    ld_reg_n = 1'b1; ld_all_n = 1'b1; idle(5);
    clr_n = 1'b0; idle(2); clr_n = 1'b1; idle(6);
    check_dacs("R10 clear code kept after release");
    pulse_all();
    check_dacs("R10 input registers hold clear code");
    pulse_reg(); pulse_all();
    check_dacs("R9 shift register survives clear");
    upd_cnt = 0;
    clr_mid = 1'b0; clr_n = 1'b0; idle(8); clr_n = 1'b1; idle(5);
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    check_dacs("R8 zero-scale clear");
    check("R11 single pulse on clear", upd_cnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(1);
    t_reset();
    t_frames();
    t_cs_clock();
    t_extra_edge();
    t_corrupt();
    t_clear();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule